// File: doc/BRIEF.md
# Accumulator Move Shifter Limiter

This block is the formatting stage between a 56-bit accumulator and a 24-bit data bus. Each accumulator has an 8-bit extension, a 24-bit high word and a 24-bit low word. On the read side, the block takes the contents of one accumulator and returns either the whole accumulator or one of its two 24-bit words. The whole accumulator can first be scaled by one bit up or down. It is then clamped to a 24-bit saturation constant when the extension carries significance. A 16-bit destination receives only the low 16 bits of the result.

On the write side, a 24-bit or 16-bit operand is turned into the format its destination needs. The destination can be the whole accumulator (sign-extended and padded with zero below), the high word alone, a plain 24-bit register or a 16-bit register. A write mask tells the register file which accumulator parts to update.

A seven-flag condition byte is kept here. The limit flag inside it is sticky, so block floating-point code can check for overflow once, after a run of moves.

Both data paths are valid/ready streams with no storage. The input ready is the output ready passed straight through. The output valid is the input valid. A transfer happens in a cycle where both are high. While the consumer holds ready low, the producer must hold its operand steady. A read that is stalled this way has no effect on the flags.

Top module: `acc_move_unit`

## Requirements
- R1: When the read source is a 24-bit word (rd_whole=0), rdo_data is bits 23:0 of the accumulator if rd_low=1 and bits 47:24 if rd_low=0. No scaling or limiting is applied, and the limit flag does not change.
- R2: When the whole accumulator is the read source with scale_mode 00 or 11 and no limiting, rdo_data is accumulator bits 47:24.
- R3: With scale_mode 01 (scale down), the output word is accumulator bits 48:25, an arithmetic shift right by one. With scale_mode 10 (scale up), the output word is bits 46:23, a shift left by one.
- R4: For a whole-accumulator read, the extension counts as in use when any bit of the scaled 56-bit value above output bit 23 differs from output bit 23. In that case the output is 24'h7FFFFF if accumulator bit 55 is 0, and 24'h800000 if it is 1.
- R5: A limiting read that completes a handshake sets ccr_flags[6] (L) at the next clock edge. L then stays set through any number of ordinary moves.
- R6: Reset clears ccr_flags. A pulse on sr_wr loads ccr_flags[6:0] from sr_data[6:0]. The flag order is L=6, E=5, U=4, N=3, Z=2, V=1, C=0. When a limiting read completes in the same cycle, the status write takes priority.
- R7: With rd_narrow=1, rdo_data[15:0] is the low 16 bits of the word formed under R1 to R4, and rdo_data[23:16] is zero.
- R8: A write with wr_dst=00 (whole accumulator) gives wro_mask=3'b111. wro_data[55:48] holds copies of operand bit 23, wro_data[47:24] holds the operand and wro_data[23:0] is zero.
- R9: A write with wr_dst=01 (high word only) gives wro_mask=3'b010. The operand appears unchanged in wro_data[47:24], and all other bits are zero.
- R10: With wr_src_narrow=1, the operand is wr_data[15:0] with 8 zero bits above it, before any destination formatting.
- R11: A write with wr_dst=10 (24-bit register) or wr_dst=11 (16-bit register) gives wro_mask=3'b001 and places the operand in wro_data[23:0]. For wr_dst=11, bits 23:16 of the operand are discarded (written as zero).
- R12: rd_ready equals rdo_ready, rdo_valid equals rd_valid, wr_ready equals wro_ready and wro_valid equals wr_valid. The flags change only on a completed read handshake or on sr_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scale_mode | input | 2 | Scaling mode: 00 none, 01 down, 10 up, 11 none |
| rd_valid | input | 1 | Read operand valid |
| rd_ready | output | 1 | Read operand accepted |
| rd_acc | input | 56 | Accumulator contents to read |
| rd_whole | input | 1 | 1: whole accumulator source; 0: 24-bit word source |
| rd_low | input | 1 | Word source select: 1 low word, 0 high word |
| rd_narrow | input | 1 | Destination is 16 bits |
| rdo_valid | output | 1 | Read result valid |
| rdo_ready | input | 1 | Read result consumer ready |
| rdo_data | output | 24 | Read result |
| wr_valid | input | 1 | Write operand valid |
| wr_ready | output | 1 | Write operand accepted |
| wr_data | input | 24 | Write operand |
| wr_src_narrow | input | 1 | Operand is 16 bits wide |
| wr_dst | input | 2 | Destination: 00 whole acc, 01 high word, 10 24-bit reg, 11 16-bit reg |
| wro_valid | output | 1 | Formatted write valid |
| wro_ready | input | 1 | Register file ready |
| wro_data | output | 56 | Formatted write value |
| wro_mask | output | 3 | Parts to update: bit2 extension, bit1 high word, bit0 low word or register |
| sr_wr | input | 1 | Load condition flags |
| sr_data | input | 7 | Flag values to load |
| ccr_flags | output | 7 | Condition flags, L in bit 6 |

## Verification
The assertions assume that an operand is not changed while it is stalled, and that scale_mode is stable across a handshake, because the flag checks trace a limit event back to the handshake cycle. They also assume sr_wr is a single-cycle control and not a stream. The bench changes every input on the falling edge, one scenario at a time. During a stall it holds each operand fixed, and it pulses sr_wr only in the scenarios that set out to test it.

// File: rtl/amsl_pkg.sv
package amsl_pkg;
  localparam int WORD_W = 24;
  localparam int EXT_W  = 8;
  localparam int NAR_W  = 16;
  localparam int ACC_W  = EXT_W + 2 * WORD_W;
  localparam int FLAG_W = 7;
  localparam int LIM_BIT = 6;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  typedef enum logic [1:0] {
    DST_WHOLE  = 2'b00,
    DST_HIGH   = 2'b01,
    DST_WORD   = 2'b10,
    DST_NARROW = 2'b11
  } wdst_e;
endpackage

// File: rtl/amsl_scaler.sv
module amsl_scaler #(
  parameter int WORD_W = amsl_pkg::WORD_W,
  parameter int EXT_W  = amsl_pkg::EXT_W
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc,
  input  logic [1:0]                mode,
  output logic [WORD_W-1:0]         word,
  output logic                      lim
);
  import amsl_pkg::*;
  localparam int AW  = EXT_W + 2 * WORD_W;
  localparam int TOP = AW - (2 * WORD_W - 1);

  logic [AW-1:0]     shifted;
  logic [TOP-1:0]    top_bits;
  logic [WORD_W-1:0] sat_pos, sat_neg;

  assign sat_pos = {1'b0, {(WORD_W-1){1'b1}}};
  assign sat_neg = {1'b1, {(WORD_W-1){1'b0}}};

  always_comb begin
    case (scale_e'(mode))
      SCL_DOWN: shifted = $unsigned($signed(acc) >>> 1);
      SCL_UP:   shifted = acc << 1;
      default:  shifted = acc;
    endcase
    top_bits = shifted[AW-1 -: TOP];
    lim      = !((&top_bits) || !(|top_bits));
    word     = lim ? (acc[AW-1] ? sat_neg : sat_pos) : shifted[2*WORD_W-1 -: WORD_W];
  end

  always_comb begin
    if (lim) begin
      assert_sat_sign_R4: assert (word[WORD_W-1] == acc[AW-1]);
    end
  end
endmodule

// File: rtl/amsl_wfmt.sv
module amsl_wfmt #(
  parameter int WORD_W = amsl_pkg::WORD_W,
  parameter int EXT_W  = amsl_pkg::EXT_W,
  parameter int NAR_W  = amsl_pkg::NAR_W
) (
  input  logic                      valid,
  input  logic [WORD_W-1:0]         din,
  input  logic                      src_narrow,
  input  logic [1:0]                dst,
  output logic [EXT_W+2*WORD_W-1:0] dout,
  output logic [2:0]                mask
);
  import amsl_pkg::*;
  localparam int AW = EXT_W + 2 * WORD_W;

  logic [WORD_W-1:0] opnd;

  always_comb begin
    opnd = src_narrow ? {{(WORD_W-NAR_W){1'b0}}, din[NAR_W-1:0]} : din;
    dout = '0;
    case (wdst_e'(dst))
      DST_WHOLE: begin
        dout = {{EXT_W{opnd[WORD_W-1]}}, opnd, {WORD_W{1'b0}}};
        mask = 3'b111;
      end
      DST_HIGH: begin
        dout[2*WORD_W-1 -: WORD_W] = opnd;
        mask = 3'b010;
      end
      DST_WORD: begin
        dout[WORD_W-1:0] = opnd;
        mask = 3'b001;
      end
      default: begin
        dout[NAR_W-1:0] = opnd[NAR_W-1:0];
        mask = 3'b001;
      end
    endcase
  end

  always_comb begin
    if (valid && mask == 3'b111) begin
      assert_whole_ext_R8: assert (((&dout[AW-1:2*WORD_W-1]) || !(|dout[AW-1:2*WORD_W-1]))
                                   && dout[WORD_W-1:0] == '0);
    end
    if (valid && src_narrow && mask == 3'b001) begin
      assert_narrow_zero_R10: assert (dout[WORD_W-1:NAR_W] == '0);
    end
  end
endmodule

// File: rtl/amsl_ccr.sv
module amsl_ccr #(
  parameter int FLAG_W  = amsl_pkg::FLAG_W,
  parameter int LIM_BIT = amsl_pkg::LIM_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_evt,
  input  logic              sr_wr,
  input  logic [FLAG_W-1:0] sr_data,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= '0;
    else if (sr_wr)     flags <= sr_data;
    else if (lim_evt)   flags[LIM_BIT] <= 1'b1;
  end

  assert_l_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[LIM_BIT]) |-> $past(sr_wr));

  assert_l_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[LIM_BIT]) |-> $past(lim_evt || sr_wr));

  assert_other_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags[LIM_BIT-1:0]) |-> $past(sr_wr));
endmodule

// File: rtl/acc_move_unit.sv
module acc_move_unit #(
  parameter int WORD_W = amsl_pkg::WORD_W,
  parameter int EXT_W  = amsl_pkg::EXT_W,
  parameter int NAR_W  = amsl_pkg::NAR_W,
  parameter int FLAG_W = amsl_pkg::FLAG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                scale_mode,
  input  logic                      rd_valid,
  output logic                      rd_ready,
  input  logic [EXT_W+2*WORD_W-1:0] rd_acc,
  input  logic                      rd_whole,
  input  logic                      rd_low,
  input  logic                      rd_narrow,
  output logic                      rdo_valid,
  input  logic                      rdo_ready,
  output logic [WORD_W-1:0]         rdo_data,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      wr_src_narrow,
  input  logic [1:0]                wr_dst,
  output logic                      wro_valid,
  input  logic                      wro_ready,
  output logic [EXT_W+2*WORD_W-1:0] wro_data,
  output logic [2:0]                wro_mask,
  input  logic                      sr_wr,
  input  logic [FLAG_W-1:0]         sr_data,
  output logic [FLAG_W-1:0]         ccr_flags
);
  logic [WORD_W-1:0] sc_word, sel_word;
  logic              sc_lim, lim_evt;

  amsl_scaler #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_scaler (
    .acc(rd_acc), .mode(scale_mode), .word(sc_word), .lim(sc_lim));

  always_comb begin
    if (rd_whole)    sel_word = sc_word;
    else if (rd_low) sel_word = rd_acc[WORD_W-1:0];
    else             sel_word = rd_acc[2*WORD_W-1 -: WORD_W];
    rdo_data = rd_narrow ? {{(WORD_W-NAR_W){1'b0}}, sel_word[NAR_W-1:0]} : sel_word;
  end

  assign rd_ready  = rdo_ready;
  assign rdo_valid = rd_valid;
  assign lim_evt   = rd_valid && rdo_ready && rd_whole && sc_lim;

  amsl_wfmt #(.WORD_W(WORD_W), .EXT_W(EXT_W), .NAR_W(NAR_W)) u_wfmt (
    .valid(wr_valid), .din(wr_data), .src_narrow(wr_src_narrow), .dst(wr_dst),
    .dout(wro_data), .mask(wro_mask));

  assign wr_ready  = wro_ready;
  assign wro_valid = wr_valid;

  amsl_ccr #(.FLAG_W(FLAG_W)) u_ccr (
    .clk(clk), .rst_n(rst_n), .lim_evt(lim_evt), .sr_wr(sr_wr),
    .sr_data(sr_data), .flags(ccr_flags));

  assert_stall_no_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rdo_ready && !sr_wr) |=> $stable(ccr_flags));

  assert_sub_no_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_whole && !sr_wr) |=> $stable(ccr_flags));
endmodule

// File: tb/test_acc_move_unit.sv
module test_acc_move_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  scale_mode = 0;
  logic        rd_valid = 0, rd_ready, rd_whole = 0, rd_low = 0, rd_narrow = 0;
  logic [55:0] rd_acc = 0;
  logic        rdo_valid, rdo_ready = 1;
  logic [23:0] rdo_data;
  logic        wr_valid = 0, wr_ready, wr_src_narrow = 0, wro_valid, wro_ready = 1;
  logic [23:0] wr_data = 0;
  logic [1:0]  wr_dst = 0;
  logic [55:0] wro_data;
  logic [2:0]  wro_mask;
  logic        sr_wr = 0;
  logic [6:0]  sr_data = 0, ccr_flags;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  acc_move_unit i_acc_move_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] m, logic [55:0] a, logic whole, logic low, logic nar);
    @(negedge clk);
    scale_mode = m; rd_acc = a; rd_whole = whole; rd_low = low; rd_narrow = nar;
    rd_valid = 1; rdo_ready = 1;
    #1;
  endtask

  task automatic idle_edge();
    @(negedge clk);
    rd_valid = 0; sr_wr = 0; wr_valid = 0;
  endtask

  task automatic sr_load(logic [6:0] v);
    @(negedge clk);
    rd_valid = 0; sr_wr = 1; sr_data = v;
    @(negedge clk);
    sr_wr = 0;
  endtask

  task automatic t_reset();
    chk("R6 reset flags", 64'(ccr_flags), 64'h0);
  endtask

  task automatic t_subword();
    rd(2'b10, 56'h01_ABCDEF_123456, 0, 0, 0);
    chk("R1 high word", 64'(rdo_data), 64'hABCDEF);
    rd(2'b01, 56'h01_ABCDEF_123456, 0, 1, 0);
    chk("R1 low word", 64'(rdo_data), 64'h123456);
    idle_edge();
    chk("R1 no limit flag", 64'(ccr_flags), 64'h0);
  endtask

  task automatic t_plain();
    rd(2'b00, 56'h00_123456_789ABC, 1, 0, 0);
    chk("R2 mode00", 64'(rdo_data), 64'h123456);
    rd(2'b11, 56'hFF_800000_000000, 1, 0, 0);
    chk("R2 mode11 negative", 64'(rdo_data), 64'h800000);
    idle_edge();
    chk("R2 no limit", 64'(ccr_flags), 64'h0);
  endtask

  task automatic t_scale();
    rd(2'b01, 56'h00_C00000_000000, 1, 0, 0);
    chk("R3 down", 64'(rdo_data), 64'h600000);
    rd(2'b10, 56'h00_200000_800000, 1, 0, 0);
    chk("R3 up", 64'(rdo_data), 64'h400001);
    idle_edge();
    chk("R3 no limit", 64'(ccr_flags), 64'h0);
  endtask

  task automatic t_limit();
    rd(2'b00, 56'h01_000000_000000, 1, 0, 0);
    chk("R4 positive sat", 64'(rdo_data), 64'h7FFFFF);
    rd(2'b00, 56'hFE_000000_000000, 1, 0, 0);
    chk("R4 negative sat", 64'(rdo_data), 64'h800000);
    rd(2'b10, 56'h00_400000_000000, 1, 0, 0);
    chk("R4 up overflow", 64'(rdo_data), 64'h7FFFFF);
    rd(2'b01, 56'h01_000000_000000, 1, 0, 0);
    chk("R4 down still in use", 64'(rdo_data), 64'h7FFFFF);
    idle_edge();
    chk("R5 L set", 64'(ccr_flags), 64'h40);
    rd(2'b00, 56'h00_000001_000000, 1, 0, 0);
    idle_edge();
    chk("R5 L sticky", 64'(ccr_flags), 64'h40);
  endtask

  task automatic t_srwrite();
    sr_load(7'h3F);
    chk("R6 load clears L", 64'(ccr_flags), 64'h3F);
    sr_load(7'h40);
    chk("R6 load L only", 64'(ccr_flags), 64'h40);
    @(negedge clk);
    scale_mode = 0; rd_acc = 56'h01_000000_000000; rd_whole = 1; rd_narrow = 0;
    rd_valid = 1; rdo_ready = 1; sr_wr = 1; sr_data = 7'h05;
    idle_edge();
    chk("R6 write wins", 64'(ccr_flags), 64'h05);
    sr_load(7'h00);
  endtask

  task automatic t_narrow_rd();
    rd(2'b00, 56'h00_123456_000000, 1, 0, 1);
    chk("R7 whole narrow", 64'(rdo_data), 64'h003456);
    rd(2'b00, 56'h00_000000_ABCDEF, 0, 1, 1);
    chk("R7 word narrow", 64'(rdo_data), 64'h00CDEF);
    rd(2'b00, 56'h02_000000_000000, 1, 0, 1);
    chk("R7 narrow after limit", 64'(rdo_data), 64'h00FFFF);
    idle_edge();
    sr_load(7'h00);
  endtask

  task automatic wr(logic [23:0] d, logic nar, logic [1:0] dst);
    @(negedge clk);
    wr_data = d; wr_src_narrow = nar; wr_dst = dst; wr_valid = 1; wro_ready = 1;
    #1;
  endtask

  task automatic t_write();
    wr(24'h800001, 0, 2'b00);
    chk("R8 whole neg data", 64'(wro_data), 64'h00FF_8000_0100_0000);
    chk("R8 whole mask", 64'(wro_mask), 64'h7);
    wr(24'h7FFFFF, 0, 2'b00);
    chk("R8 whole pos data", 64'(wro_data), 64'h0000_7FFF_FF00_0000);
    wr(24'h800001, 0, 2'b01);
    chk("R9 high data", 64'(wro_data), 64'h0000_8000_0100_0000);
    chk("R9 high mask", 64'(wro_mask), 64'h2);
    wr(24'hAB8123, 1, 2'b10);
    chk("R10 narrow src to word", 64'(wro_data), 64'h008123);
    wr(24'hAB8123, 1, 2'b00);
    chk("R10 narrow src to whole", 64'(wro_data), 64'h0000_0081_2300_0000);
    wr(24'hAB8123, 0, 2'b11);
    chk("R11 word to narrow", 64'(wro_data), 64'h008123);
    chk("R11 narrow mask", 64'(wro_mask), 64'h1);
    wr(24'hAB8123, 0, 2'b10);
    chk("R11 word reg", 64'(wro_data), 64'hAB8123);
    idle_edge();
  endtask

  task automatic t_handshake();
    @(negedge clk);
    scale_mode = 0; rd_acc = 56'h01_000000_000000; rd_whole = 1; rd_narrow = 0;
    rd_valid = 1; rdo_ready = 0; wr_valid = 1; wro_ready = 0;
    #1;
    chk("R12 rd_ready low", 64'(rd_ready), 64'h0);
    chk("R12 rdo_valid", 64'(rdo_valid), 64'h1);
    chk("R12 wr_ready low", 64'(wr_ready), 64'h0);
    chk("R12 wro_valid", 64'(wro_valid), 64'h1);
    @(negedge clk);
    chk("R12 stall no flag", 64'(ccr_flags), 64'h0);
    rdo_ready = 1; wro_ready = 1;
    #1;
    chk("R12 rd_ready high", 64'(rd_ready), 64'h1);
    idle_edge();
    chk("R12 flag on handshake", 64'(ccr_flags), 64'h40);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_subword();
    t_plain();
    t_scale();
    t_limit();
    t_srwrite();
    t_narrow_rd();
    t_write();
    t_handshake();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule